// File: doc/BRIEF.md
# Two-Line Pulse Command Decoder

This block turns activity on two pulse lines, called START and END here, into mode commands and a small reference-select register. A pulse on one line alone is a command. A lone START pulse asks for a switch to the local reference, and a lone END pulse asks for a switch back to the RF clock. Each command is issued when its pulse falls. When the two pulses overlap, the pair carries one data bit and no command. The bit is a 1 when START rose first and a 0 when END rose first. Bits shift into a 4-bit select register.

Bit 3 of the register selects the external DDS reference. Bits 2..0 name one of eight crystal oscillators in binary, where 0 means the first crystal. The block drives the power-enable lines of the crystals. While a new value is being shifted in, the crystal that was in use before stays powered next to the crystal decoded from the current register value. This gives the new oscillator time to settle. A START command then drops the old crystal, so only the selected one stays on.

The two pulse inputs are asynchronous. They pass through synchronizers on a clock fast enough to resolve the 50 ns minimum pulse width, overlap and lead/lag. The block has no other control interface.

Top module: `pulse_cmd_decoder`

## Requirements
- R1: After reset, `sel_reg` is 4'b0000, `xtal_en` is 8'h01 (only crystal 0 on), and neither command strobe is high.
- R2: A START pulse with END low for its whole duration produces exactly one `ref_cmd` strobe after START falls. It produces no `rf_cmd` and leaves `sel_reg` unchanged.
- R3: An END pulse with START low for its whole duration produces exactly one `rf_cmd` strobe after END falls. Repeating it any number of times leaves `sel_reg` and `xtal_en` unchanged.
- R4: If START rises, and END rises while START is still high, a 1 is shifted into `sel_reg[0]`. The pair issues no command, including when either line later falls.
- R5: If END rises, and START rises while END is still high, a 0 is shifted into `sel_reg[0]`. The pair issues no command.
- R6: Each shift moves `sel_reg` one place toward bit 3. After four bits, the first bit sent sits in bit 3 and the last bit sent sits in bit 0.
- R7: While no START command has followed the latest shifts, `xtal_en` is the one-hot decode of `sel_reg[2:0]` (bit i set for value i) ORed with the crystal that was enabled before the sequence began. The decode ignores `sel_reg[3]`. At most two enables are ever high.
- R8: After a `ref_cmd`, `xtal_en` holds only the one-hot decode of `sel_reg[2:0]`.
- R9: If both lines rise in the same sampled cycle, nothing is shifted and no command is issued until both lines are low again.
- R10: Each command strobe is high for exactly one clock cycle per command, and `ref_cmd` and `rf_cmd` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_in | input | 1 | Asynchronous START pulse line |
| end_in | input | 1 | Asynchronous END pulse line |
| ref_cmd | output | 1 | One-cycle strobe: switch to reference |
| rf_cmd | output | 1 | One-cycle strobe: switch to RF clock |
| sel_reg | output | 4 | Select register; bit 3 = DDS, bits 2..0 = crystal index |
| xtal_en | output | 8 | Crystal oscillator power enables |

## Verification
The hardest state to reach from the ports is the window after a partial or complete shift sequence and before the START command that follows it. In that window two enables are legitimately high, and the old crystal must survive every intermediate shift. The bench sends overlapped pulse pairs one bit at a time. After each bit it compares `xtal_en` with the union of the newly decoded crystal and the crystal kept from before, and only then issues START to see the old enable drop. A separate scenario raises both lines on the same edge, which reaches the pair-tracking state without any shift.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_START = 2'd1,
    PS_END   = 2'd2,
    PS_PAIR  = 2'd3
  } pair_state_e;

  typedef struct packed {
    logic ref_stb;
    logic rf_stb;
    logic shift_stb;
    logic shift_bit;
  } cmd_evt_t;
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pcd_pair_fsm.sv
module pcd_pair_fsm
  import pcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     s_lvl,
  input  logic     e_lvl,
  output cmd_evt_t evt
);
  pair_state_e st_q, st_d;
  cmd_evt_t    evt_q, evt_d;

  always_comb begin
    st_d  = st_q;
    evt_d = '0;
    unique case (st_q)
      PS_IDLE: begin
        unique case ({s_lvl, e_lvl})
          2'b10:   st_d = PS_START;
          2'b01:   st_d = PS_END;
          2'b11:   st_d = PS_PAIR;   // simultaneous rise: no bit
          default: st_d = PS_IDLE;
        endcase
      end
      PS_START: begin
        unique case ({s_lvl, e_lvl})
          2'b11: begin
            st_d = PS_PAIR;
            evt_d.shift_stb = 1'b1;
            evt_d.shift_bit = 1'b1;
          end
          2'b00: begin
            st_d = PS_IDLE;
            evt_d.ref_stb = 1'b1;
          end
          2'b01: begin
            st_d = PS_END;
            evt_d.ref_stb = 1'b1;
          end
          default: st_d = PS_START;
        endcase
      end
      PS_END: begin
        unique case ({s_lvl, e_lvl})
          2'b11: begin
            st_d = PS_PAIR;
            evt_d.shift_stb = 1'b1;
            evt_d.shift_bit = 1'b0;
          end
          2'b00: begin
            st_d = PS_IDLE;
            evt_d.rf_stb = 1'b1;
          end
          2'b10: begin
            st_d = PS_START;
            evt_d.rf_stb = 1'b1;
          end
          default: st_d = PS_END;
        endcase
      end
      default: begin
        // overlapped pair: trailing edges carry no command
        if (!s_lvl && !e_lvl) st_d = PS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      evt_q <= '0;
    end else begin
      st_q  <= st_d;
      evt_q <= evt_d;
    end
  end

  assign evt = evt_q;
endmodule

// File: rtl/pcd_select.sv
module pcd_select #(
  parameter int N_XTAL = 8,
  localparam int IDX_W = $clog2(N_XTAL),
  localparam int SEL_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_stb,
  input  logic             shift_bit,
  input  logic             commit,
  output logic [SEL_W-1:0] sel,
  output logic [N_XTAL-1:0] en
);
  logic [SEL_W-1:0]  sel_q;
  logic [N_XTAL-1:0] keep_q;
  logic [N_XTAL-1:0] dec;

  always_comb begin
    dec = '0;
    dec[sel_q[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      keep_q <= {{(N_XTAL-1){1'b0}}, 1'b1};
    end else begin
      if (shift_stb) sel_q <= {sel_q[SEL_W-2:0], shift_bit};
      if (commit)    keep_q <= dec;
    end
  end

  assign sel = sel_q;
  assign en  = keep_q | dec;
endmodule

// File: rtl/pulse_cmd_decoder.sv
module pulse_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_XTAL      = 8,
  localparam int SEL_W      = $clog2(N_XTAL) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_in,
  input  logic              end_in,
  output logic              ref_cmd,
  output logic              rf_cmd,
  output logic [SEL_W-1:0]  sel_reg,
  output logic [N_XTAL-1:0] xtal_en
);
  logic [1:0] raw;
  logic [1:0] lvl;
  cmd_evt_t   evt;

  assign raw = {start_in, end_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    pcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw[g]),
      .q    (lvl[g])
    );
  end

  pcd_pair_fsm u_fsm (
    .clk  (clk),
    .rst_n(rst_n),
    .s_lvl(lvl[1]),
    .e_lvl(lvl[0]),
    .evt  (evt)
  );

  pcd_select #(.N_XTAL(N_XTAL)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_stb(evt.shift_stb),
    .shift_bit(evt.shift_bit),
    .commit   (evt.ref_stb),
    .sel      (sel_reg),
    .en       (xtal_en)
  );

  assign ref_cmd = evt.ref_stb;
  assign rf_cmd  = evt.rf_stb;
endmodule

// File: rtl/pulse_cmd_decoder_chk.sv
module pulse_cmd_decoder_chk #(
  parameter int SEL_W  = 4,
  parameter int N_XTAL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_cmd,
  input logic              rf_cmd,
  input logic [SEL_W-1:0]  sel_reg,
  input logic [N_XTAL-1:0] xtal_en
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_cmd && rf_cmd)); // R10

  AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> !ref_cmd); // R10

  AST_RF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cmd |=> !rf_cmd); // R10

  AST_RF_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rf_cmd |=> ($stable(sel_reg) && $stable(xtal_en))); // R3

  AST_EN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(xtal_en) >= 1) && ($countones(xtal_en) <= 2)); // R7

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> ($countones(xtal_en) == 1)); // R8
endmodule

bind pulse_cmd_decoder pulse_cmd_decoder_chk #(.SEL_W(SEL_W), .N_XTAL(N_XTAL)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ref_cmd(ref_cmd),
  .rf_cmd (rf_cmd),
  .sel_reg(sel_reg),
  .xtal_en(xtal_en)
);

// File: tb/sim_pulse_cmd_decoder.sv
module sim_pulse_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_in = 1'b0;
  logic       end_in = 1'b0;
  logic       ref_cmd, rf_cmd;
  logic [3:0] sel_reg;
  logic [7:0] xtal_en;

  int n_chk = 0;
  int n_bad = 0;
  int ref_hi = 0;
  int rf_hi = 0;
  logic [3:0] m_sel;
  logic [7:0] m_keep;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .start_in(start_in), .end_in(end_in),
    .ref_cmd(ref_cmd), .rf_cmd(rf_cmd), .sel_reg(sel_reg), .xtal_en(xtal_en)
  );

  always @(posedge clk) begin
    if (ref_cmd) ref_hi++;
    if (rf_cmd)  rf_hi++;
  end

  function automatic logic [7:0] onehot(input logic [2:0] i);
    return 8'h01 << i;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lone_start();
    @(negedge clk) start_in = 1'b1;
    wait_cyc(10);
    start_in = 1'b0;
    wait_cyc(10);
  endtask

  task automatic lone_end();
    @(negedge clk) end_in = 1'b1;
    wait_cyc(10);
    end_in = 1'b0;
    wait_cyc(10);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    if (b) start_in = 1'b1; else end_in = 1'b1;
    wait_cyc(5);
    if (b) end_in = 1'b1; else start_in = 1'b1;
    wait_cyc(5);
    if (b) start_in = 1'b0; else end_in = 1'b0;
    wait_cyc(5);
    if (b) end_in = 1'b0; else start_in = 1'b0;
    wait_cyc(10);
    m_sel = {m_sel[2:0], b};
  endtask

  task automatic t_reset();
    chk("R1 sel_reg", sel_reg, 0);
    chk("R1 xtal_en", xtal_en, 8'h01);
    chk("R1 strobes", ref_hi + rf_hi, 0);
  endtask

  task automatic t_start_alone();
    int r0 = ref_hi;
    int f0 = rf_hi;
    lone_start();
    m_keep = onehot(m_sel[2:0]);
    chk("R2 ref_cmd cycles", ref_hi - r0, 1);
    chk("R2 no rf_cmd", rf_hi - f0, 0);
    chk("R2 sel_reg", sel_reg, m_sel);
  endtask

  task automatic t_end_twice();
    int r0 = ref_hi;
    int f0 = rf_hi;
    logic [7:0] en0 = xtal_en;
    lone_end();
    chk("R3 rf_cmd first", rf_hi - f0, 1);
    lone_end();
    chk("R3 rf_cmd repeat", rf_hi - f0, 2);
    chk("R3 no ref_cmd", ref_hi - r0, 0);
    chk("R3 sel_reg", sel_reg, m_sel);
    chk("R3 xtal_en", xtal_en, en0);
  endtask

  task automatic t_word(input logic [3:0] w);
    int r0 = ref_hi;
    int f0 = rf_hi;
    for (int i = 3; i >= 0; i--) begin
      send_bit(w[i]);
      chk(w[i] ? "R4 shift one" : "R5 shift zero", sel_reg[0], w[i]);
      chk("R7 xtal_en mid", xtal_en, m_keep | onehot(m_sel[2:0]));
    end
    chk("R6 order", sel_reg, w);
    chk("R4 R5 no command", (ref_hi - r0) + (rf_hi - f0), 0);
    lone_start();
    m_keep = onehot(m_sel[2:0]);
    chk("R8 xtal_en", xtal_en, onehot(w[2:0]));
    chk("R10 one ref cycle", ref_hi - r0, 1);
  endtask

  task automatic t_simul();
    int r0 = ref_hi;
    int f0 = rf_hi;
    @(negedge clk);
    start_in = 1'b1;
    end_in   = 1'b1;
    wait_cyc(8);
    start_in = 1'b0;
    wait_cyc(6);
    end_in = 1'b0;
    wait_cyc(10);
    chk("R9 sel_reg", sel_reg, m_sel);
    chk("R9 no command", (ref_hi - r0) + (rf_hi - f0), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    m_sel = 4'h0;
    m_keep = 8'h01;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_start_alone();
    t_end_twice();
    t_word(4'b1010);
    t_simul();
    t_word(4'b1111);
    t_end_twice();
    t_word(4'b0011);
    t_start_alone();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule